// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block computes the next accumulator value for an 8-bit datapath and keeps a five-flag status byte. The accumulator value and a second operand come in on ports. The second operand may come from a register, from memory or from an immediate field; the block does not care which. A 4-bit operation code picks the function. The new accumulator value leaves the block combinationally in the same cycle. The status byte is held in a register inside the block. That register loads the freshly computed flags on any clock edge where the enable is high. Its current contents feed back into the next computation, because the rotates through carry and the carry-preserving operations read the stored carry.

Operation codes: 0 add, 1 subtract, 2 increment, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 complement, 8 compare, 9 rotate left circular, 10 rotate left through carry, 11 rotate right circular, 12 rotate right through carry. Codes 13 to 15 are reserved.

Status byte positions: bit 7 sign (S), bit 6 zero (Z), bit 4 auxiliary carry (AC), bit 2 parity (P), bit 0 carry (CY). Bits 5, 3 and 1 carry no meaning.

Top module: `accalu_top`

## Requirements
- R1: The status byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 always read 0.
- R2: Every operation that writes S, Z and P sets them from its result. S is result bit 7. Z is 1 when the result is 0x00. P is 1 when the result holds an even number of ones.
- R3: Add (code 0) gives A+B modulo 256. CY is the carry out of bit 7. AC is the carry out of bit 3.
- R4: Subtract (code 1) gives A-B modulo 256. CY is 1 on a borrow (B > A unsigned). AC is the carry out of bit 3 of A + ~B + 1.
- R5: Increment (code 2) adds 1 and decrement (code 3) subtracts 1. Both update S, Z, P and AC by the rules of add 1 and subtract 1. CY keeps its stored value.
- R6: AND, OR and XOR (codes 4, 5, 6) give the bitwise result and clear CY. AC becomes 1 for AND and 0 for OR and XOR.
- R7: Complement (code 7) inverts every accumulator bit, ignores the operand and leaves all flags unchanged.
- R8: Compare (code 8) returns the accumulator unchanged. It sets the flags exactly as subtract would for the same inputs.
- R9: The rotates behave as follows.
  - Left circular (code 9) moves bit 7 into bit 0 and into CY.
  - Left through carry (code 10) moves bit 7 into CY and the stored CY into bit 0.
  - Right circular (code 11) moves bit 0 into bit 7 and into CY.
  - Right through carry (code 12) moves bit 0 into CY and the stored CY into bit 7.
  - All four leave S, Z, AC and P unchanged.
- R10: The status register loads only on a rising clock edge with enable high. With enable low it holds its value, while the result output still follows the inputs.
- R11: Reserved codes 13 to 15 pass the accumulator through and leave all flags unchanged.
- R12: A low reset input clears the status byte to 0x00 at once. Release takes effect through a two-stage synchronizer, so the register accepts loads from the third rising edge after reset goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Status register load enable |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| opnd | input | 8 | Second operand (register, memory or immediate) |
| acc_out | output | 8 | New accumulator value (combinational) |
| flags_q | output | 8 | Registered status byte |

## Verification
Within one clock cycle a rotate through carry both reads the stored carry and writes a new carry into the status register. A fault here could let the result see the carry it is about to produce. The bench forces this case by issuing two rotates through carry back to back with enable held high. For each rotate it compares the combinational result against the carry left by the previous operation, and checks the registered carry against the bit shifted out. Every vector is preceded by an add that plants a known status byte. This makes the carry-in and the untouched flags predictable from the requirements alone.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  localparam int FLAG_W = 8;
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_AC  = 4;
  localparam int FB_P   = 2;
  localparam int FB_CY  = 0;
  localparam logic [FLAG_W-1:0] FLAG_USED =
    (8'h1 << FB_S) | (8'h1 << FB_Z) | (8'h1 << FB_AC) | (8'h1 << FB_P) | (8'h1 << FB_CY);

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_INC = 4'd2,  OP_DEC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMA = 4'd7,
    OP_CMP = 4'd8,  OP_RLC = 4'd9,  OP_RAL = 4'd10, OP_RRC = 4'd11,
    OP_RAR = 4'd12, OP_RS0 = 4'd13, OP_RS1 = 4'd14, OP_RS2 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac
);
  localparam int HB = 4;
  logic [W-1:0] bx;
  logic [W:0]   full;
  logic [HB:0]  low;

  always_comb begin
    bx   = sub ? ~b : b;
    full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    low  = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, sub};
    sum  = full[W-1:0];
    cy   = full[W] ^ sub;   // carry on add, borrow on subtract
    ac   = low[HB];
  end
endmodule

// File: rtl/alu_flaggen.sv
module alu_flaggen #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         s,
  output logic         z,
  output logic         p
);
  always_comb begin
    s = val[W-1];
    z = (val == '0);
    p = ~(^val);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      opnd,
  input  logic [FLAG_W-1:0] flags_cur,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flags_nxt
);
  alu_op_e      opc;
  logic [W-1:0] as_b, as_sum, lg, fg_in;
  logic         as_sub, as_cy, as_ac;
  logic         fs, fz, fp;

  assign opc = alu_op_e'(op);

  always_comb begin
    as_sub = (opc == OP_SUB) || (opc == OP_CMP) || (opc == OP_DEC);
    as_b   = ((opc == OP_INC) || (opc == OP_DEC)) ? {{(W-1){1'b0}}, 1'b1} : opnd;
    unique case (opc)
      OP_AND:  lg = acc & opnd;
      OP_OR:   lg = acc | opnd;
      default: lg = acc ^ opnd;
    endcase
    fg_in = ((opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR)) ? lg : as_sum;
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(acc), .b(as_b), .sub(as_sub), .sum(as_sum), .cy(as_cy), .ac(as_ac)
  );

  alu_flaggen #(.W(W)) u_flaggen (
    .val(fg_in), .s(fs), .z(fz), .p(fp)
  );

  always_comb begin
    logic [FLAG_W-1:0] f;
    f   = flags_cur;
    res = acc;
    unique case (opc)
      OP_ADD, OP_SUB, OP_CMP: begin
        if (opc != OP_CMP) res = as_sum;
        f[FB_S] = fs; f[FB_Z] = fz; f[FB_P] = fp;
        f[FB_AC] = as_ac; f[FB_CY] = as_cy;
      end
      OP_INC, OP_DEC: begin
        res = as_sum;
        f[FB_S] = fs; f[FB_Z] = fz; f[FB_P] = fp; f[FB_AC] = as_ac;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = lg;
        f[FB_S] = fs; f[FB_Z] = fz; f[FB_P] = fp;
        f[FB_AC] = (opc == OP_AND); f[FB_CY] = 1'b0;
      end
      OP_CMA: res = ~acc;
      OP_RLC: begin res = {acc[W-2:0], acc[W-1]};       f[FB_CY] = acc[W-1]; end
      OP_RAL: begin res = {acc[W-2:0], flags_cur[FB_CY]}; f[FB_CY] = acc[W-1]; end
      OP_RRC: begin res = {acc[0], acc[W-1:1]};         f[FB_CY] = acc[0];   end
      OP_RAR: begin res = {flags_cur[FB_CY], acc[W-1:1]}; f[FB_CY] = acc[0];   end
      default: ;
    endcase
    flags_nxt = f & FLAG_USED;
  end
endmodule

// File: rtl/accalu_top.sv
module accalu_top
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [3:0]          op,
  input  logic [W-1:0]        acc_in,
  input  logic [W-1:0]        opnd,
  output logic [W-1:0]        acc_out,
  output logic [FLAG_W-1:0]   flags_q
);
  logic                rst_s1, rst_sync_n;
  logic [FLAG_W-1:0]   flags_calc, flags_d;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  alu_core #(.W(W)) u_core (
    .op(op), .acc(acc_in), .opnd(opnd), .flags_cur(flags_q),
    .res(acc_out), .flags_nxt(flags_calc)
  );

  always_comb begin
    flags_d = flags_q;
    if (en) flags_d = flags_calc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  // R1: meaningless positions stay clear
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flags_q & ~FLAG_USED) == '0);
  // R10: no load without enable
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(flags_q));
  // R7: complement touches no flag
  a_r7_cma_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op == OP_CMA) |=> $stable(flags_q));
  // R8: compare keeps the accumulator
  a_r8_cmp_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_CMP) |-> (acc_out == acc_in));
  // R5: increment and decrement preserve carry
  a_r5_carry_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && (op == OP_INC || op == OP_DEC)) |=> (flags_q[FB_CY] == $past(flags_q[FB_CY])));
  // R6: logic operations clear carry
  a_r6_logic_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !flags_q[FB_CY]);
  // R9: rotates alter only carry
  a_r9_rot_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op >= OP_RLC && op <= OP_RAR) |=> (flags_q[7:1] == $past(flags_q[7:1])));
  // R11: reserved codes leave flags alone
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op > OP_RAR) |=> $stable(flags_q));
endmodule

// File: tb/accalu_tb_top.sv
module accalu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  logic       clk = 1'b0;
  logic       rst_n, en;
  logic [3:0] op;
  logic [7:0] acc_in, opnd, acc_out, flags_q;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in),
    .opnd(opnd), .acc_out(acc_out), .flags_q(flags_q)
  );

  // {req, op, acc, opnd, carry_in, exp_res, exp_flags}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd3,  4'd0,  8'h3A, 8'h28, 1'b0, 8'h62, 8'h10},
    {4'd3,  4'd0,  8'hB3, 8'h4D, 1'b0, 8'h00, 8'h55},
    {4'd3,  4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 8'h45},
    {4'd4,  4'd1,  8'h05, 8'h07, 1'b0, 8'hFE, 8'h81},
    {4'd4,  4'd1,  8'h42, 8'h42, 1'b0, 8'h00, 8'h54},
    {4'd2,  4'd1,  8'h10, 8'h01, 1'b0, 8'h0F, 8'h04},
    {4'd5,  4'd2,  8'hFF, 8'h00, 1'b0, 8'h00, 8'h54},
    {4'd5,  4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 8'h85},
    {4'd5,  4'd3,  8'h01, 8'h00, 1'b0, 8'h00, 8'h54},
    {4'd6,  4'd4,  8'hF0, 8'h3C, 1'b1, 8'h30, 8'h14},
    {4'd6,  4'd5,  8'h81, 8'h02, 1'b1, 8'h83, 8'h80},
    {4'd6,  4'd6,  8'h5A, 8'h5A, 1'b1, 8'h00, 8'h44},
    {4'd7,  4'd7,  8'h5A, 8'hFF, 1'b1, 8'hA5, 8'h55},
    {4'd8,  4'd8,  8'h20, 8'h30, 1'b0, 8'h20, 8'h95},
    {4'd8,  4'd8,  8'h44, 8'h44, 1'b0, 8'h44, 8'h54},
    {4'd9,  4'd9,  8'h81, 8'h00, 1'b0, 8'h03, 8'h45},
    {4'd9,  4'd9,  8'h40, 8'h00, 1'b1, 8'h80, 8'h54},
    {4'd9,  4'd10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h45},
    {4'd9,  4'd10, 8'h01, 8'h00, 1'b1, 8'h03, 8'h54},
    {4'd9,  4'd11, 8'h01, 8'h00, 1'b0, 8'h80, 8'h45},
    {4'd9,  4'd12, 8'h01, 8'h00, 1'b0, 8'h00, 8'h45},
    {4'd9,  4'd12, 8'h02, 8'h00, 1'b1, 8'h81, 8'h54},
    {4'd11, 4'd13, 8'h77, 8'h12, 1'b1, 8'h77, 8'h55}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check(input string t, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, got, exp);
    end
  endtask

  // drive at falling edge; result sampled 1 time unit later
  task automatic drive(input logic e, input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    en = e; op = o; acc_in = a; opnd = b;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  // plant carry: ADD FF+01 -> flags 0x55, ADD 00+00 -> flags 0x44
  task automatic plant(input logic c);
    if (c) drive(1'b1, 4'd0, 8'hFF, 8'h01);
    else   drive(1'b1, 4'd0, 8'h00, 8'h00);
    after_edge();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = 4'd0; acc_in = '0; opnd = '0;
    repeat (3) @(negedge clk);
    // R12: reset value
    check("R12", "reset flags", flags_q, 8'h00);
    rst_n = 1'b1;
    // enable across release; first two edges must not load
    drive(1'b1, 4'd0, 8'hFF, 8'h01);
    after_edge();
    check("R12", "load during sync", flags_q, 8'h00);
    after_edge();
    after_edge();
    check("R12", "load after sync", flags_q, 8'h55);

    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      v = VEC[i];
      plant(v[16]);
      drive(1'b1, v[36:33], v[32:25], v[24:17]);
      check(tag(v[40:37]), "result", acc_out, v[15:8]);
      after_edge();
      check(tag(v[40:37]), "flags", flags_q, v[7:0]);
      // R1 and R2 on every vector: unused bits clear
      check("R1", "unused bits", flags_q & 8'h2A, 8'h00);
    end

    // R10: enable low keeps flags, result still live
    plant(1'b1);
    drive(1'b0, 4'd1, 8'h05, 8'h07);
    check("R10", "result en low", acc_out, 8'hFE);
    after_edge();
    check("R10", "flags en low", flags_q, 8'h55);

    // R9/R10: back-to-back rotates through carry, same-cycle read and write
    plant(1'b1);
    drive(1'b1, 4'd10, 8'h00, 8'h00);
    check("R9", "ral1 result", acc_out, 8'h01);
    after_edge();
    check("R9", "ral1 carry", flags_q, 8'h54);
    drive(1'b1, 4'd10, 8'h80, 8'h00);
    check("R9", "ral2 result", acc_out, 8'h00);
    after_edge();
    check("R9", "ral2 carry", flags_q, 8'h55);
    drive(1'b1, 4'd12, 8'h00, 8'h00);
    check("R9", "rar after ral", acc_out, 8'h80);
    after_edge();

    // R2: parity odd with sign
    plant(1'b0);
    drive(1'b1, 4'd5, 8'h80, 8'h00);
    after_edge();
    check("R2", "sign odd parity", flags_q, 8'h80);

    // R12: asynchronous clear mid-run
    plant(1'b1);
    drive(1'b0, 4'd0, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    check("R12", "async clear", flags_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule